// File: doc/BRIEF.md
# Double-Rate Column Data Serializer

This block sits between a panel timing generator and the column drivers of a flat panel. Each pixel clock it accepts one 18-bit pixel, made of three 6-bit colour components, together with a data-enable and the column start pulse that the timing generator sends to the column drivers. It packs each pixel onto nine narrow lanes, three per colour, and sends two bits per lane per pixel clock. The upper three bits of every component go out in the half-cycle that follows the rising clock edge. The lower three bits go out in the half-cycle that follows the falling edge. At 85 MHz this gives 170 Mb/s per lane.

The two half-words leave the block as registered 9-bit words, `rise_bits` and `fall_bits`. An external double-rate output cell combines them, so the block stays synchronous to one clock. A forwarded-clock enable tells that cell when to toggle the clock lane. A short internal delay line holds each pixel so that the first active pixel of a line reaches the lanes a fixed number of pixel clocks after the start pulse rises. With the default depth that is two clocks.

Top module: `col_ddr_serializer`

## Requirements
- R1: The lanes form three groups of three: red drives lane bits 2:0, green drives 5:3 and blue drives 8:6 of both `rise_bits` and `fall_bits`. A pixel with only one component non-zero lights only that component's group.
- R2: In `rise_bits`, lane j of a colour group carries bit j+3 of that colour component, for j = 0, 1, 2.
- R3: In `fall_bits`, lane j of a colour group carries bit j of that colour component, for j = 0, 1, 2.
- R4: A pixel presented in the same clock cycle as `col_start` shows on `rise_bits` and `fall_bits` two clock cycles later. Both halves of one pixel appear in the same cycle.
- R5: A pixel presented with `pix_de` low yields zero on both `rise_bits` and `fall_bits` two cycles later, whatever the colour inputs hold.
- R6: `fwd_clk_en` is high exactly in the cycles whose input, two cycles earlier, had `pix_de` or `col_start` high. A start pulse with `pix_de` low therefore enables the clock while the lanes stay zero.
- R7: While `rst_n` is low, `rise_bits`, `fall_bits` and `fwd_clk_en` are zero without waiting for a clock edge. Pixels held in the delay line when reset is asserted never reach the lanes.
- R8: Pixels on consecutive cycles with `pix_de` high appear on consecutive output cycles, in order, with no gap and no repeat.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside |
| pix_r | input | 6 | Red component |
| pix_g | input | 6 | Green component |
| pix_b | input | 6 | Blue component |
| pix_de | input | 1 | Pixel valid for the current clock |
| col_start | input | 1 | Column start pulse, the line timing reference |
| rise_bits | output | 9 | Lane bits for the half-cycle after the rising edge |
| fall_bits | output | 9 | Lane bits for the half-cycle after the falling edge |
| fwd_clk_en | output | 1 | Enable for the forwarded clock lane |

## Verification
Two functions can land on the same output cycle. One is the start-pulse alignment, which drives `fwd_clk_en` and R4. The other is the data-enable gating of the lanes, R5. Directed cycles raise `col_start` together with an active pixel, with `pix_de` low, and directly after a line's last pixel. Random cycles then mix start, enable and colour values freely. Each output cycle is judged against the input applied two cycles earlier, so a start pulse that lifts the clock enable and an idle pixel that zeroes the lanes are checked together in one sample.

// File: rtl/cds_pkg.sv
package cds_pkg;

  localparam int COLOR_W    = 6;
  localparam int NUM_COLORS = 3;
  localparam int HALF_W     = COLOR_W / 2;
  localparam int LANE_W     = NUM_COLORS * HALF_W;
  localparam int PIX_W      = NUM_COLORS * COLOR_W;

  // One pixel-clock beat travelling down the alignment line.
  // rgb packs red in the lowest field, then green, then blue.
  typedef struct packed {
    logic             start;
    logic             de;
    logic [PIX_W-1:0] rgb;
  } beat_t;

  localparam beat_t BEAT_IDLE = '{start: 1'b0, de: 1'b0, rgb: '0};

endpackage

// File: rtl/cds_rst_sync.sv
module cds_rst_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_sync_no
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_no = sync_q[SYNC_STAGES-1];

endmodule

// File: rtl/cds_align_pipe.sv
module cds_align_pipe
  import cds_pkg::*;
#(
  parameter int STAGES = 1
) (
  input  logic  clk,
  input  logic  rst_ni,
  input  beat_t beat_i,
  output beat_t beat_o
);

  generate
    if (STAGES == 0) begin : g_pass
      assign beat_o = beat_i;
    end else begin : g_line
      beat_t stage_q   [STAGES];
      beat_t stage_d   [STAGES];
      beat_t stage_src [STAGES];
      logic  rgb_load  [STAGES];

      always_comb begin
        for (int i = 0; i < STAGES; i++) begin
          stage_src[i] = (i == 0) ? beat_i : stage_q[(i == 0) ? 0 : i-1];
        end
      end

      // Control bits move every cycle; colour bits load only for valid
      // pixels and otherwise hold, saving toggles during blanking.
      always_comb begin
        for (int i = 0; i < STAGES; i++) begin
          rgb_load[i]       = stage_src[i].de;
          stage_d[i].start  = stage_src[i].start;
          stage_d[i].de     = stage_src[i].de;
          stage_d[i].rgb    = rgb_load[i] ? stage_src[i].rgb : stage_q[i].rgb;
        end
      end

      always_ff @(posedge clk or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < STAGES; i++) begin
            stage_q[i] <= BEAT_IDLE;
          end
        end else begin
          for (int i = 0; i < STAGES; i++) begin
            stage_q[i] <= stage_d[i];
          end
        end
      end

      assign beat_o = stage_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/cds_lane_split.sv
module cds_lane_split #(
  parameter int COLOR_W = 6,
  parameter int HALF_W  = COLOR_W / 2
) (
  input  logic [COLOR_W-1:0] color_i,
  input  logic               valid_i,
  output logic [HALF_W-1:0]  upper_o,
  output logic [HALF_W-1:0]  lower_o
);

  // Upper half rides the rising-edge slot, lower half the falling-edge
  // slot; both are forced low when the pixel is not valid.
  always_comb begin
    if (valid_i) begin
      upper_o = color_i[COLOR_W-1:HALF_W];
      lower_o = color_i[HALF_W-1:0];
    end else begin
      upper_o = '0;
      lower_o = '0;
    end
  end

endmodule

// File: rtl/col_ddr_serializer.sv
module col_ddr_serializer
  import cds_pkg::*;
#(
  parameter int ALIGN_DLY   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [COLOR_W-1:0] pix_r,
  input  logic [COLOR_W-1:0] pix_g,
  input  logic [COLOR_W-1:0] pix_b,
  input  logic               pix_de,
  input  logic               col_start,
  output logic [LANE_W-1:0]  rise_bits,
  output logic [LANE_W-1:0]  fall_bits,
  output logic               fwd_clk_en
);

  // The output register is the last stage of the alignment delay.
  localparam int PIPE_STAGES = (ALIGN_DLY > 1) ? ALIGN_DLY - 1 : 0;

  logic  rst_core_n;
  beat_t beat_in;
  beat_t beat_aligned;

  logic [LANE_W-1:0] rise_d, rise_q;
  logic [LANE_W-1:0] fall_d, fall_q;
  logic              en_d, en_q;

  cds_rst_sync #(
    .SYNC_STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk         (clk),
    .rst_ni      (rst_n),
    .rst_sync_no (rst_core_n)
  );

  // rst_n also clears the datapath directly so that outputs drop at once
  // on assertion; the synchronised copy governs release.
  logic rst_path_n;
  assign rst_path_n = rst_n & rst_core_n;

  always_comb begin
    beat_in.start = col_start;
    beat_in.de    = pix_de;
    beat_in.rgb   = {pix_b, pix_g, pix_r};
  end

  cds_align_pipe #(
    .STAGES (PIPE_STAGES)
  ) u_align (
    .clk    (clk),
    .rst_ni (rst_path_n),
    .beat_i (beat_in),
    .beat_o (beat_aligned)
  );

  genvar c;
  generate
    for (c = 0; c < NUM_COLORS; c++) begin : g_color
      cds_lane_split #(
        .COLOR_W (COLOR_W),
        .HALF_W  (HALF_W)
      ) u_split (
        .color_i (beat_aligned.rgb[c*COLOR_W +: COLOR_W]),
        .valid_i (beat_aligned.de),
        .upper_o (rise_d[c*HALF_W +: HALF_W]),
        .lower_o (fall_d[c*HALF_W +: HALF_W])
      );
    end
  endgenerate

  always_comb begin
    en_d = beat_aligned.de | beat_aligned.start;
  end

  always_ff @(posedge clk or negedge rst_path_n) begin
    if (!rst_path_n) begin
      rise_q <= '0;
      fall_q <= '0;
      en_q   <= 1'b0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
      en_q   <= en_d;
    end
  end

  assign rise_bits  = rise_q;
  assign fall_bits  = fall_q;
  assign fwd_clk_en = en_q;

endmodule

// File: rtl/col_ddr_serializer_chk.sv
module col_ddr_serializer_chk
  import cds_pkg::*;
#(
  parameter int ALIGN_DLY   = 2,
  parameter int SYNC_STAGES = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic [COLOR_W-1:0] pix_r,
  input logic [COLOR_W-1:0] pix_g,
  input logic [COLOR_W-1:0] pix_b,
  input logic               pix_de,
  input logic               col_start,
  input logic [LANE_W-1:0]  rise_bits,
  input logic [LANE_W-1:0]  fall_bits,
  input logic               fwd_clk_en
);

  localparam int WARM = SYNC_STAGES + ALIGN_DLY;

  logic [3:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm_q <= '0;
    end else if (warm_q != 4'hF) begin
      warm_q <= warm_q + 4'd1;
    end
  end

  // R7: outputs are quiet while reset is held
  assert_reset_quiet_R7: assert property (@(posedge clk)
    !rst_n |-> (rise_bits == '0 && fall_bits == '0 && !fwd_clk_en));

  // R5/R6: any lane activity implies an enabled forwarded clock
  assert_lane_needs_clk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_bits != '0 || fall_bits != '0) |-> fwd_clk_en);

  generate
    if (ALIGN_DLY == 2 && WARM < 15) begin : g_two
      assert_idle_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= WARM && !$past(pix_de, 2)) |-> (rise_bits == '0 && fall_bits == '0));

      assert_rise_map_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= WARM && $past(pix_de, 2)) |->
          rise_bits == {$past(pix_b[5:3], 2), $past(pix_g[5:3], 2), $past(pix_r[5:3], 2)});

      assert_fall_map_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= WARM && $past(pix_de, 2)) |->
          fall_bits == {$past(pix_b[2:0], 2), $past(pix_g[2:0], 2), $past(pix_r[2:0], 2)});

      assert_clk_en_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q >= WARM) |-> (fwd_clk_en == ($past(pix_de, 2) || $past(col_start, 2))));
    end
  endgenerate

endmodule

bind col_ddr_serializer col_ddr_serializer_chk #(
  .ALIGN_DLY   (ALIGN_DLY),
  .SYNC_STAGES (SYNC_STAGES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_r      (pix_r),
  .pix_g      (pix_g),
  .pix_b      (pix_b),
  .pix_de     (pix_de),
  .col_start  (col_start),
  .rise_bits  (rise_bits),
  .fall_bits  (fall_bits),
  .fwd_clk_en (fwd_clk_en)
);

// File: tb/col_ddr_serializer_tb.sv
module col_ddr_serializer_tb;

  logic       clk;
  logic       rst_n;
  logic [5:0] pix_r, pix_g, pix_b;
  logic       pix_de, col_start;
  logic [8:0] rise_bits, fall_bits;
  logic       fwd_clk_en;

  int checks;
  int errors;

  // history of inputs: h0 = last driven, h1 = driven one cycle before
  logic       h0_de, h1_de, h0_st, h1_st;
  logic [5:0] h0_r, h1_r, h0_g, h1_g, h0_b, h1_b;
  string      h0_tag, h1_tag;

  col_ddr_serializer u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pix_r      (pix_r),
    .pix_g      (pix_g),
    .pix_b      (pix_b),
    .pix_de     (pix_de),
    .col_start  (col_start),
    .rise_bits  (rise_bits),
    .fall_bits  (fall_bits),
    .fwd_clk_en (fwd_clk_en)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [8:0] exp_rise(logic de, logic [5:0] r, logic [5:0] g, logic [5:0] b);
    return de ? {b[5:3], g[5:3], r[5:3]} : 9'd0;
  endfunction

  function automatic logic [8:0] exp_fall(logic de, logic [5:0] r, logic [5:0] g, logic [5:0] b);
    return de ? {b[2:0], g[2:0], r[2:0]} : 9'd0;
  endfunction

  task automatic check9(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic clear_hist();
    h0_de = 0; h1_de = 0; h0_st = 0; h1_st = 0;
    h0_r = 0; h1_r = 0; h0_g = 0; h1_g = 0; h0_b = 0; h1_b = 0;
    h0_tag = "R7"; h1_tag = "R7";
  endtask

  // Called at a falling edge: check outputs for the beat driven two
  // steps ago, then drive the next beat.
  task automatic step(string tag, logic de, logic st, logic [5:0] r, logic [5:0] g, logic [5:0] b);
    check9({h1_tag, " rise"}, rise_bits, exp_rise(h1_de, h1_r, h1_g, h1_b));
    check9({h1_tag, " fall"}, fall_bits, exp_fall(h1_de, h1_r, h1_g, h1_b));
    check9({h1_tag, " R6 clk_en"}, {8'd0, fwd_clk_en}, {8'd0, h1_de | h1_st});
    h1_de = h0_de; h1_st = h0_st; h1_r = h0_r; h1_g = h0_g; h1_b = h0_b; h1_tag = h0_tag;
    h0_de = de; h0_st = st; h0_r = r; h0_g = g; h0_b = b; h0_tag = tag;
    pix_de = de; col_start = st; pix_r = r; pix_g = g; pix_b = b;
    @(negedge clk);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) step(tag, 1'b0, 1'b0, 6'h2A, 6'h15, 6'h3F);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check9("R7 rise in reset", rise_bits, 9'd0);
    check9("R7 fall in reset", fall_bits, 9'd0);
    check9("R7 en in reset", {8'd0, fwd_clk_en}, 9'd0);
    clear_hist();
    @(negedge clk);
    pix_de = 1'b1; col_start = 1'b1; pix_r = 6'h3F; pix_g = 6'h3F; pix_b = 6'h3F;
    @(negedge clk);
    @(negedge clk);
    check9("R7 rise held", rise_bits, 9'd0);
    check9("R7 en held", {8'd0, fwd_clk_en}, 9'd0);
    rst_n = 1'b1;
    idle("R7", 4);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    checks = 0; errors = 0;
    seed = 32'h5EED_0C0D;
    void'($urandom(seed));
    pix_de = 0; col_start = 0; pix_r = 0; pix_g = 0; pix_b = 0;
    clear_hist();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    do_reset();

    // R1 lane groups
    step("R1 red", 1'b1, 1'b1, 6'h3F, 6'h00, 6'h00);
    step("R1 green", 1'b1, 1'b0, 6'h00, 6'h3F, 6'h00);
    step("R1 blue", 1'b1, 1'b0, 6'h00, 6'h00, 6'h3F);
    idle("R5", 3);
    // R2/R3 bit order within a group
    step("R2 R3 upper", 1'b1, 1'b0, 6'h38, 6'h20, 6'h08);
    step("R2 R3 lower", 1'b1, 1'b0, 6'h07, 6'h04, 6'h01);
    step("R2 R3 mixed", 1'b1, 1'b0, 6'h29, 6'h16, 6'h0B);
    idle("R5", 3);
    // R4 start with first pixel; R8 contiguous line
    step("R4 first", 1'b1, 1'b1, 6'h11, 6'h22, 6'h33);
    for (int i = 0; i < 16; i++)
      step("R8 line", 1'b1, 1'b0, 6'(i), 6'(i * 3), 6'(63 - i));
    // R6 start with de low, then start right after last pixel
    step("R6 start idle", 1'b0, 1'b1, 6'h3F, 6'h3F, 6'h3F);
    step("R5 gap", 1'b0, 1'b0, 6'h3F, 6'h3F, 6'h3F);
    step("R4 second", 1'b1, 1'b1, 6'h3F, 6'h00, 6'h2A);
    step("R6 start after", 1'b0, 1'b1, 6'h01, 6'h02, 6'h03);
    idle("R5", 3);

    // random traffic
    for (int i = 0; i < 3000; i++) begin
      logic de, st;
      de = ($urandom % 4) != 0;
      st = ($urandom % 8) == 0;
      step("R2 R3 R5 R6 random", de, st, 6'($urandom), 6'($urandom), 6'($urandom));
    end

    // R7 reset in mid-line discards in-flight pixels
    step("R7 preline", 1'b1, 1'b1, 6'h3F, 6'h3F, 6'h3F);
    step("R7 preline", 1'b1, 1'b0, 6'h3F, 6'h3F, 6'h3F);
    do_reset();
    idle("R7 after", 4);
    step("R4 after reset", 1'b1, 1'b1, 6'h0F, 6'h30, 6'h21);
    idle("R5", 3);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule